// File: doc/BRIEF.md
# Active-Low Latched Interrupt Request Controller

This block gathers eight maskable interrupt sources into a single level-sensitive, active-low request line to the processor. Seven of the sources are single-cycle event strobes: break key, other key, serial byte received, serial output needed, and three timer underflows. The eighth is a live level that reports whether the serial output shift register is empty. Software reaches the block through a plain bus. It writes an 8-bit enable register and reads an 8-bit status word.

Status uses inverted polarity. A bit sits at 1 while nothing is pending. It drops to 0 when its enabled source fires, and it stays at 0 until software writes 0 to the matching enable bit. That one write both disables the source and releases the latch. Bit 3 is not latched. It always shows the inverse of the serial-output-empty level, whatever its enable bit holds. The enable bit for position 3 only decides whether an empty shift register drives the request line.

The block holds control and status registers only, so no port carries a data stream and no port takes a valid/ready handshake. All pins are plain control and status signals.

Top module: `irq_latch_ctrl`

## Requirements
- R1: On a synchronous reset the enable register holds 0, every latched status bit reads 1 and `irq_n` is high.
- R2: The bit order is fixed. Bit 7 is break key, bit 6 other key, bit 5 serial input ready, bit 4 serial output needed, bit 3 transmission finished, bit 2 timer 4, bit 1 timer 2 and bit 0 timer 1. A strobe on a latched position whose enable bit is 1 makes that status bit read 0 one clock later.
- R3: A strobe on a latched position whose enable bit is 0 is ignored. The status bit keeps reading 1.
- R4: A latched status bit at 0 stays at 0 through later strobes and through writes that leave its enable bit at 1.
- R5: Writing 0 to an enable bit disables that source and makes its latched status bit read 1 one clock later. Writing 1 to an enable bit leaves that bit's latch unchanged.
- R6: When a strobe and a write fall in the same cycle, the release wins if the write puts 0 in that bit. The strobe is judged against the enable value held before the write.
- R7: Status bit 3 reads the inverse of `ser_out_empty` in the same cycle. It is not affected by enable bit 3 or by strobe bit 3.
- R8: `irq_n` is low exactly when some latched status bit reads 0, or when enable bit 3 is 1 and `ser_out_empty` is 1.
- R9: A written enable value takes effect from the next clock and holds until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable value to write |
| src_evt | input | 8 | Single-cycle source strobes, one per bit (bit 3 unused) |
| ser_out_empty | input | 1 | High while the serial output shift register is empty |
| stat_rdata | output | 8 | Status word, 0 means pending |
| irq_n | output | 1 | Interrupt request to the processor, active low |

## Verification
A source strobe and an enable write can land in the same clock. The bench provokes this in four ways: a strobe alongside a disabling write, alongside an enabling write on a source that was off, alongside a rewrite that keeps the source on, and on a bit that is already latched. In each case the bench judges the status word one clock later against the rule that the release wins and that the strobe sees the old enable value. The sweep over every enable value also checks that strobes on disabled positions and on bit 3 never latch. In the same sweep the request line follows both the latched bits and the live empty level.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int unsigned SRC_W    = 8;
  localparam int unsigned LIVE_BIT = 3;

  function automatic logic [SRC_W-1:0] latched_mask(input int unsigned live);
    logic [SRC_W-1:0] m;
    m = '1;
    m[live] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (wr) en_q <= wdata;
  end
endmodule

// File: rtl/irq_stat_cell.sv
module irq_stat_cell (
  input  logic clk,
  input  logic rst,
  input  logic release_req,
  input  logic fire,
  output logic stat_q
);
  // Active-low latch: 1 idle, 0 pending. Release has priority over fire.
  always_ff @(posedge clk) begin
    if (rst)              stat_q <= 1'b1;
    else if (release_req) stat_q <= 1'b1;
    else if (fire)        stat_q <= 1'b0;
  end
endmodule

// File: rtl/irq_req_merge.sv
module irq_req_merge #(
  parameter int unsigned W    = 8,
  parameter int unsigned LIVE = 3
) (
  input  logic [W-1:0] stat,
  input  logic         live_en,
  input  logic         live_empty,
  output logic         irq_n
);
  localparam logic [W-1:0] LMASK = ~({{(W-1){1'b0}}, 1'b1} << LIVE);
  logic pend_latched;
  logic pend_live;
  always_comb begin
    pend_latched = |(~stat & LMASK);
    pend_live    = live_en & live_empty;
    irq_n        = ~(pend_latched | pend_live);
  end
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int unsigned NSRC     = irq_latch_pkg::SRC_W,
  parameter int unsigned LIVE_IDX = irq_latch_pkg::LIVE_BIT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_wdata,
  input  logic [NSRC-1:0] src_evt,
  input  logic            ser_out_empty,
  output logic [NSRC-1:0] stat_rdata,
  output logic            irq_n
);
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] rel_vec;

  irq_en_reg #(.W(NSRC)) u_en (
    .clk   (clk),
    .rst   (rst),
    .wr    (en_wr),
    .wdata (en_wdata),
    .en_q  (en_q)
  );

  assign rel_vec = en_wr ? ~en_wdata : '0;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (i == LIVE_IDX) begin : g_live
      assign stat_rdata[i] = ~ser_out_empty;
    end else begin : g_latch
      irq_stat_cell u_cell (
        .clk         (clk),
        .rst         (rst),
        .release_req (rel_vec[i]),
        .fire        (src_evt[i] & en_q[i]),
        .stat_q      (stat_rdata[i])
      );
    end
  end

  irq_req_merge #(.W(NSRC), .LIVE(LIVE_IDX)) u_merge (
    .stat       (stat_rdata),
    .live_en    (en_q[LIVE_IDX]),
    .live_empty (ser_out_empty),
    .irq_n      (irq_n)
  );
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk #(
  parameter int unsigned NSRC     = 8,
  parameter int unsigned LIVE_IDX = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            en_wr,
  input logic [NSRC-1:0] en_wdata,
  input logic [NSRC-1:0] src_evt,
  input logic            ser_out_empty,
  input logic [NSRC-1:0] stat_rdata,
  input logic            irq_n,
  input logic [NSRC-1:0] en_q
);
  localparam logic [NSRC-1:0] LM = ~({{(NSRC-1){1'b0}}, 1'b1} << LIVE_IDX);

  logic armed = 1'b0;
  logic [NSRC-1:0] rel_c;
  always_ff @(posedge clk) armed <= !rst;
  assign rel_c = en_wr ? (~en_wdata & LM) : '0;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> ((stat_rdata & LM) == LM) && irq_n);

  assert_no_fire_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    armed |=> ((($past(stat_rdata) & ~stat_rdata) & LM & ~($past(en_q) & $past(src_evt))) == '0));

  assert_hold_pending_R4: assert property (@(posedge clk) disable iff (rst)
    armed |=> ((~$past(stat_rdata) & LM & ~$past(rel_c) & stat_rdata) == '0));

  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && rel_c != '0) |=> ((stat_rdata & $past(rel_c)) == $past(rel_c)));

  assert_live_bit_R7: assert property (@(posedge clk) disable iff (rst)
    armed |-> (stat_rdata[LIVE_IDX] == !ser_out_empty));

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    armed |-> (irq_n == !(((stat_rdata & LM) != LM) || (en_q[LIVE_IDX] && ser_out_empty))));
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(.NSRC(NSRC), .LIVE_IDX(LIVE_IDX)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .en_wr         (en_wr),
  .en_wdata      (en_wdata),
  .src_evt       (src_evt),
  .ser_out_empty (ser_out_empty),
  .stat_rdata    (stat_rdata),
  .irq_n         (irq_n),
  .en_q          (en_q)
);

// File: tb/irq_latch_ctrl_bench.sv
`timescale 1ns/1ps
module irq_latch_ctrl_bench;
  localparam int  N  = 8;
  localparam real TP = 4.0;
  localparam logic [N-1:0] LM = 8'hF7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_wr = 1'b0;
  logic [N-1:0] en_wdata = '0;
  logic [N-1:0] src_evt = '0;
  logic ser_out_empty = 1'b0;
  logic [N-1:0] stat_rdata;
  logic irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [N-1:0] en_m = '0;
  logic [N-1:0] lat_m = '1;

  always #(TP/2) clk = ~clk;

  irq_latch_ctrl u_irq_latch_ctrl (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_wdata(en_wdata),
    .src_evt(src_evt), .ser_out_empty(ser_out_empty),
    .stat_rdata(stat_rdata), .irq_n(irq_n)
  );

  function automatic logic [N-1:0] exp_stat();
    logic [N-1:0] s;
    s = lat_m & LM;
    s[3] = ~ser_out_empty;
    return s;
  endfunction

  function automatic logic exp_irq();
    return !(((lat_m & LM) != LM) || (en_m[3] && ser_out_empty));
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, stat_rdata, exp_stat());
    chk(req, {7'd0, irq_n}, {7'd0, exp_irq()});
  endtask

  // One clock: drive, clock, update model from the requirement rules, release inputs.
  task automatic step(input logic we, input logic [N-1:0] wd, input logic [N-1:0] ev);
    logic [N-1:0] rel, fire;
    @(negedge clk);
    en_wr = we; en_wdata = wd; src_evt = ev;
    @(posedge clk);
    #1;
    rel  = we ? (~wd & LM) : '0;       // R5 / R6 release wins
    fire = en_m & ev & LM & ~rel;      // R2 / R3 old enable judged
    lat_m = (lat_m & ~fire) | rel;
    if (we) en_m = wd;                 // R9
    en_wr = 1'b0; src_evt = '0;
  endtask

  initial begin
    #(TP * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    en_m = '0; lat_m = '1;
    chk_all("R1 reset");

    // R3: strobes with all sources disabled
    step(1'b0, '0, 8'hFF);
    chk_all("R3 disabled ignored");

    // R2/R3/R8 sweep over every enable value
    for (int e = 0; e < 256; e++) begin
      logic [N-1:0] ev;
      ev = 8'((e * 37 + 11) ^ (e >> 2)) | 8'h08;
      step(1'b1, 8'(e), '0);
      step(1'b0, '0, ev);
      chk_all("R2 sweep latch");
      ser_out_empty = e[0];
      #1;
      chk_all("R8 sweep irq with live bit");
      step(1'b1, '0, '0);
      chk_all("R5 sweep release all");
      ser_out_empty = 1'b0;
    end

    // R7: live bit vs enable, strobe and empty level
    for (int k = 0; k < 4; k++) begin
      step(1'b1, k[1] ? 8'h08 : 8'h00, '0);
      ser_out_empty = k[0];
      step(1'b0, '0, 8'h08);
      chk_all("R7 live bit");
    end
    ser_out_empty = 1'b0;

    // R4: latched bit holds through more strobes and keep-enabled rewrites
    step(1'b1, 8'hF7, '0);
    step(1'b0, '0, 8'h01);
    step(1'b0, '0, 8'h81);
    step(1'b1, 8'hF7, 8'h01);
    chk_all("R4 hold pending");
    chk("R4 bits 7 and 0 low", stat_rdata & 8'h81, 8'h00);

    // R5: partial release, other pending bit kept
    step(1'b1, 8'hF6, '0);
    chk_all("R5 partial release");
    chk("R5 bit0 released bit7 held", stat_rdata & 8'h81, 8'h01);

    // R6: strobe with disabling write on enabled source
    step(1'b1, 8'hFF, '0);
    step(1'b1, 8'hDF, 8'h20);
    chk_all("R6 release beats strobe");
    // R6: strobe with enabling write on disabled source uses old enable
    step(1'b1, 8'hFF, 8'h20);
    chk_all("R6 old enable ignores strobe");
    chk("R6 bit5 idle", stat_rdata & 8'h20, 8'h20);
    // R6: strobe with keep-enabled write latches
    step(1'b1, 8'hFF, 8'h04);
    chk_all("R6 keep enable latches");
    chk("R6 bit2 pending", stat_rdata & 8'h04, 8'h00);

    // R9: enable persists without writes
    step(1'b0, '0, '0);
    step(1'b0, '0, 8'h40);
    chk_all("R9 enable holds");

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    en_m = '0; lat_m = '1;
    ser_out_empty = 1'b1;
    #1;
    chk_all("R1 reset mid-run");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule